// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

The block drives one PWM pin whose average duty carries more bits than its base counter. The duty word has two fields. The upper field sets how many clock ticks each base period stays high. The lower field is a dither value that adds one more tick to a chosen subset of the periods in a repeating group of 2^DW periods. Averaged over that group, the duty resolves steps of 1/2^DW of a tick. An output filter then sees only a small ripple at the group rate.

The block picks the periods that get the extra tick by comparing the dither value with the bit-reversed index of the period inside the group. This spreads those periods evenly through the group, so they never form one run. A new duty word is offered with a one-clock load strobe. It takes effect only at the next pattern start, so a pattern always runs with a single word. A one-clock flag marks the first clock of every pattern.

Top module: `hrpwm_gen`

## Requirements
- R1: While rst_ni is low, pwm_o and pat_start_o are both low.
- R2: A base period lasts 2^CW clocks. Within a period, the high ticks are contiguous and begin at the period's first clock.
- R3: Let coarse be duty bits [CW+DW-1:DW], dither be bits [DW-1:0], and p be the period index inside the pattern (0 to 2^DW-1). When coarse is below 2^CW-1, period p is high for coarse+1 ticks if dither > bitreverse(p), and for coarse ticks otherwise.
- R4: Over one pattern of 2^DW periods, the number of high clocks equals coarse*2^DW + dither. So exactly dither periods carry the extra tick.
- R5: When dither equals 2^(DW-1), periods with and without the extra tick alternate, starting with an extended period at p = 0.
- R6: An all-zero duty word holds pwm_o low on every clock.
- R7: When coarse equals 2^CW-1, pwm_o is high on every clock, whatever the dither value.
- R8: pat_start_o is high for exactly one clock, at the first clock of each pattern (period 0, tick 0), and is low on every other clock. The first clock after reset release is a pattern start.
- R9: A word presented with load_i is used from the start of the next pattern. The rest of the current pattern keeps the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | CW+DW | Duty word: coarse field in the upper CW bits, dither field in the lower DW bits |
| load_i | input | 1 | One-clock strobe that captures duty_i for the next pattern |
| pwm_o | output | 1 | PWM output, registered |
| pat_start_o | output | 1 | High on the first clock of each dither pattern |

## Verification
The bench uses a small configuration of 4 coarse bits and 3 dither bits, so each pattern is 128 clocks. Every clock of a full pattern is compared with a model of the period-index rule.

- A dither of zero separates the plain coarse PWM from the dithered path.
- Dither values of one, three and seven test the bit-reversed selection against a simple threshold on the period count.
- A dither of half the range confirms that the extended periods alternate rather than bunch.
- The zero word and the saturated coarse value cover both ends of the range.
- Each word is loaded mid-pattern, and the remaining clocks are checked against the old word to show that the switch waits for the boundary.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;
  parameter int unsigned HRPWM_CW_DEF = 10;
  parameter int unsigned HRPWM_DW_DEF = 6;
endpackage

// File: rtl/hrpwm_timebase.sv
module hrpwm_timebase #(
  parameter int unsigned CW = 10,
  parameter int unsigned DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] tick_q_o,
  output logic [DW-1:0] per_q_o,
  output logic [CW-1:0] tick_d_o,
  output logic [DW-1:0] per_d_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] TICK_MAX = {CW{1'b1}};
  localparam logic [DW-1:0] PER_MAX  = {DW{1'b1}};

  logic [CW-1:0] tick_q;
  logic [DW-1:0] per_q;
  logic          tick_last;

  assign tick_last = (tick_q == TICK_MAX);
  assign tick_d_o  = tick_last ? '0 : tick_q + 1'b1;
  assign per_d_o   = tick_last ? per_q + 1'b1 : per_q;
  assign wrap_o    = tick_last && (per_q == PER_MAX);

  // reset parks on the last position so the first edge enters a pattern start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= TICK_MAX;
      per_q  <= PER_MAX;
    end else begin
      tick_q <= tick_d_o;
      per_q  <= per_d_o;
    end
  end

  assign tick_q_o = tick_q;
  assign per_q_o  = per_q;

  AST_TICK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q == TICK_MAX) |=> (tick_q == '0)); // R2
  AST_PER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q != TICK_MAX) |=> $stable(per_q)); // R3
endmodule

// File: rtl/hrpwm_duty_latch.sv
module hrpwm_duty_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] duty_i,
  input  logic         adv_i,
  output logic [W-1:0] duty_q_o,
  output logic [W-1:0] duty_d_o
);
  logic         pend_q;
  logic [W-1:0] pend_word_q;
  logic [W-1:0] duty_q;
  logic         take;

  assign take     = adv_i && pend_q;
  assign duty_d_o = take ? pend_word_q : duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_word_q <= '0;
      duty_q      <= '0;
    end else begin
      if (take) duty_q <= pend_word_q;
      if (load_i) begin
        pend_q      <= 1'b1;
        pend_word_q <= duty_i;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign duty_q_o = duty_q;

  AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(duty_q)); // R9
endmodule

// File: rtl/hrpwm_dither_sel.sv
module hrpwm_dither_sel #(
  parameter int unsigned CW = 10,
  parameter int unsigned DW = 6
) (
  input  logic [CW+DW-1:0] duty_i,
  input  logic [CW-1:0]    tick_i,
  input  logic [DW-1:0]    per_i,
  output logic             level_o
);
  logic [CW-1:0] coarse;
  logic [DW-1:0] dith;
  logic [DW-1:0] per_rev;
  logic          extra;
  logic          sat;
  logic [CW:0]   hi_ticks;

  assign coarse = duty_i[CW+DW-1:DW];
  assign dith   = duty_i[DW-1:0];

  for (genvar g = 0; g < DW; g++) begin : g_rev
    assign per_rev[g] = per_i[DW-1-g];
  end

  // bit reversal spreads the extended periods evenly over the pattern
  assign extra    = (dith > per_rev);
  assign sat      = &coarse;
  assign hi_ticks = {1'b0, coarse} + {{CW{1'b0}}, extra};
  assign level_o  = sat || ({1'b0, tick_i} < hi_ticks);
endmodule

// File: rtl/hrpwm_gen.sv
module hrpwm_gen
  import hrpwm_pkg::*;
#(
  parameter int unsigned CW = HRPWM_CW_DEF,
  parameter int unsigned DW = HRPWM_DW_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW+DW-1:0] duty_i,
  input  logic            load_i,
  output logic            pwm_o,
  output logic            pat_start_o
);
  localparam int unsigned W = CW + DW;

  logic [CW-1:0] tick_q, tick_d;
  logic [DW-1:0] per_q, per_d;
  logic          wrap;
  logic [W-1:0]  duty_q, duty_d;
  logic          level_d;
  logic          pwm_q, start_q;

  hrpwm_timebase #(.CW(CW), .DW(DW)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_q_o(tick_q),
    .per_q_o (per_q),
    .tick_d_o(tick_d),
    .per_d_o (per_d),
    .wrap_o  (wrap)
  );

  hrpwm_duty_latch #(.W(W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .duty_i  (duty_i),
    .adv_i   (wrap),
    .duty_q_o(duty_q),
    .duty_d_o(duty_d)
  );

  // evaluate the next position so the pin is a clean register output
  hrpwm_dither_sel #(.CW(CW), .DW(DW)) u_sel (
    .duty_i (duty_d),
    .tick_i (tick_d),
    .per_i  (per_d),
    .level_o(level_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pwm_q   <= level_d;
      start_q <= wrap;
    end
  end

  assign pwm_o       = pwm_q;
  assign pat_start_o = start_q;

  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!pwm_o && !pat_start_o)); // R1
  AST_RISE_AT_TICK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> (tick_q == '0)); // R2
  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |-> !pwm_o); // R6
  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&duty_q[W-1:DW]) |-> pwm_o); // R7
  AST_FLAG_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_start_o |-> ((tick_q == '0) && (per_q == '0))); // R8
  AST_FLAG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_start_o |=> !pat_start_o); // R8
endmodule

// File: tb/hrpwm_gen_tb.sv
`timescale 1ns/1ps
module hrpwm_gen_tb;
  localparam int CW = 4;
  localparam int DW = 3;
  localparam int W  = CW + DW;
  localparam int NP = 1 << CW;
  localparam int NPAT = 1 << (CW + DW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] duty = '0;
  logic load = 1'b0;
  logic pwm, pstart;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cur_word = 0;

  always #10 clk = ~clk;

  hrpwm_gen #(.CW(CW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .load_i(load),
    .pwm_o(pwm), .pat_start_o(pstart)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rev(input int p);
    int r = 0;
    for (int b = 0; b < DW; b++) if (p[b]) r |= 1 << (DW - 1 - b);
    return r;
  endfunction

  function automatic int exp_level(input int word, input int pos);
    int c = word >> DW;
    int d = word & ((1 << DW) - 1);
    int t = pos % NP;
    int p = pos / NP;
    if (c == NP - 1) return 1;
    return (t < c + ((d > rev(p)) ? 1 : 0)) ? 1 : 0;
  endfunction

  // load mid-pattern, check rest of old pattern, then a full new pattern
  task automatic run_case(input int c, input int d, input string tag);
    int word = (c << DW) | d;
    int highs = 0;
    int bad = 0;
    int bad_act = 0;
    int bad_exp = 0;
    int flag_bad = 0;
    while (!pstart) @(negedge clk);
    @(negedge clk);
    duty = W'(word);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    for (int pos = 2; pos < NPAT; pos++) begin
      if (pwm != exp_level(cur_word, pos)) begin
        bad++; bad_act = pwm; bad_exp = exp_level(cur_word, pos);
      end
      @(negedge clk);
    end
    check(bad == 0, "R9 old word held until boundary", bad_act, bad_exp);
    bad = 0;
    cur_word = word;
    for (int pos = 0; pos < NPAT; pos++) begin
      if (pstart != (pos == 0)) flag_bad++;
      if (pwm != exp_level(word, pos)) begin
        if (bad == 0) begin bad_act = pwm; bad_exp = exp_level(word, pos); end
        bad++;
      end
      highs += pwm;
      @(negedge clk);
    end
    check(bad == 0, tag, bad_act, bad_exp);
    check(flag_bad == 0, "R8 flag only at pattern start", flag_bad, 0);
    check(pstart == 1'b1, "R8 flag at next pattern start", pstart, 1);
    check(highs == ((c == NP - 1) ? NPAT : c * (1 << DW) + d),
          "R4 high clocks per pattern", highs,
          (c == NP - 1) ? NPAT : c * (1 << DW) + d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R1 pwm low in reset", pwm, 0);
    check(pstart == 1'b0, "R1 flag low in reset", pstart, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pstart == 1'b1, "R8 first clock after reset is pattern start", pstart, 1);
    run_case(6, 0, "R2 plain coarse, contiguous from tick 0");
    run_case(6, 1, "R3 dither 1 extends period 0 only");
    run_case(9, 3, "R3 dither 3 bit-reversed selection");
    run_case(5, 4, "R5 half dither alternates");
    run_case(0, 5, "R3 coarse 0 single-tick pulses");
    run_case(14, 7, "R3 dither 7 near top");
    run_case(NP - 1, 2, "R7 saturated coarse constant high");
    run_case(0, 0, "R6 zero word constant low");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule